// File: doc/BRIEF.md
# Synchronous Burst SRAM with Selectable Output Stage

A single-port synchronous memory that serves four-beat bursts. Every input is captured on the rising clock edge: the address, the write data, the byte enables, the strobes and the two static mode inputs. A burst starts with a start strobe. The start strobe loads the address. An advance strobe then steps to the next beat, and a deselect strobe ends the burst. If a start carries any byte enable, or the global write, the burst is a write burst. Otherwise it is a read burst.

The `flow_thru` input chooses the read path. When it is high, array data goes straight to the output. When it is low, the data passes through an output register and each beat arrives one cycle later. The `lin_order` input chooses how the low two address bits move through a burst: counting up modulo four, or XORed with the beat number. Both inputs tied low gives interleaved order with the registered output. Read data leaves on `rdata` and is qualified by `rvalid`; there is no bidirectional bus.

Top module: `sbsram_top`

## Requirements
- R1: The array holds 2**ADDR_W words of 32 bits, each reached by its full `addr` value and separate from every other word. The default is ADDR_W=10, and ADDR_W=16 gives the 64K-word configuration.
- R2: With `flow_thru`=1, a read burst whose start is registered at edge E drives beat 0 on `rdata` with `rvalid`=1 from E to the next edge. Each later beat follows one edge after the previous one (2-1-1-1).
- R3: With `flow_thru`=0, every beat appears one cycle later than in R2, through an output register (3-1-1-1). If no earlier read is still in flight, `rvalid` is 0 in the cycle right after the start edge.
- R4: With `lin_order`=1, beat k uses low address bits (s + k) mod 4, where s is the low two bits of the start address. The upper address bits stay fixed.
- R5: With `lin_order`=0, beat k uses low address bits s XOR k. With both mode inputs low, the block runs interleaved and pipelined.
- R6: During a burst, a cycle with `start`, `adv` and `desel` all low repeats the current beat. The address does not change.
- R7: Bit i of `byte_we` writes bits 8i+7..8i and leaves the other bytes unchanged. A start with any enable set opens a write burst. Later beats of that burst write with that cycle's enables.
- R8: `we_all`=1 writes all four bytes, whatever the value of `byte_we`.
- R9: A write completes in one cycle. A read started in the very next cycle to the same address returns the new data.
- R10: A registered `desel` ends the burst and wins over `start` and `adv`. With `flow_thru`=1, `rvalid` falls right after that edge. With `flow_thru`=0, the last beat stays driven for one more cycle before `rvalid` falls.
- R11: Reset is synchronous and active low. After an edge with `rst_n`=0, `rvalid`=0, `rdata`=0 and no burst is active.
- R12: `rdata` is all zeros whenever `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flow_thru | input | 1 | 1: unregistered read path; 0: registered read path |
| lin_order | input | 1 | 1: linear beat order; 0: interleaved beat order |
| start | input | 1 | Loads `addr` and opens a burst |
| adv | input | 1 | Steps to the next beat of the open burst |
| desel | input | 1 | Ends the open burst |
| we_all | input | 1 | Writes every byte lane |
| byte_we | input | LANES (4) | Per-byte write enables |
| addr | input | ADDR_W | Word address captured at burst start |
| wdata | input | DATA_W (32) | Write data for the current beat |
| rdata | output | DATA_W (32) | Read data, zero when not valid |
| rvalid | output | 1 | Marks a read beat on `rdata` |

## Verification
Read bursts are run from every start offset in both beat orders and both output paths. This separates the linear order from the interleaved order, because the two agree only at some offsets. It also separates the one-cycle path from the two-cycle path by the position of the first valid beat. Held-advance bursts show that a repeat differs from a step. Partial-lane writes, then a global write with a single enable, separate lane masking from the override. The tail of each burst, a deselect that arrives with a start, and a reset in mid-burst show how the output releases on each path.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
// Package: constants and types shared by the burst SRAM modules.
// Assumes bursts are always four beats long and lanes are 8 bits wide.
package sbsram_pkg;

    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int LANE_W = 8;

    // Kind of burst held in the registered control stage
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } burst_op_e;

    // Low address bits of a beat: modulo count or XOR with the beat number
    function automatic logic [BEAT_W-1:0] beat_lo(
        input logic [BEAT_W-1:0] first,
        input logic [BEAT_W-1:0] step,
        input logic              linear
    );
        logic [BEAT_W-1:0] sum;
        sum = first + step;
        return linear ? sum : (first ^ step);
    endfunction

endpackage

// File: rtl/sbsram_seq.sv
`timescale 1ns/1ps
// Module: sbsram_seq
// The input register stage and the burst sequencer. It captures every input
// on the rising edge, holds the kind of burst and its beat number, and forms
// the array address of the current beat.
// Assumes: ADDR_W > BEAT_W; the mode inputs are static during a burst.
module sbsram_seq
    import sbsram_pkg::*;
#(
    parameter  int ADDR_W = 10,
    parameter  int LANES  = 4,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_thru,
    input  logic              lin_order,
    input  logic              start,
    input  logic              adv,
    input  logic              desel,
    input  logic              we_all,
    input  logic [LANES-1:0]  byte_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output burst_op_e         op_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [LANES-1:0]  wbe_o,
    output logic              flow_o
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] first_q;
    logic [BEAT_W-1:0] step_q;
    logic              lin_q;
    burst_op_e         op_q;
    logic              any_lane;

    // A start with any lane enable, or with the global write, opens a write burst
    assign any_lane = we_all | (|byte_we);

    // Capture the mode inputs, write data and effective lane mask every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q   <= 1'b0;
            flow_o  <= 1'b0;
            wdata_o <= '0;
            wbe_o   <= '0;
        end else begin
            lin_q   <= lin_order;
            flow_o  <= flow_thru;
            wdata_o <= wdata;
            wbe_o   <= we_all ? {LANES{1'b1}} : byte_we;
        end
    end

    // Burst state: deselect first, then start, then advance; otherwise hold the beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            hi_q    <= '0;
            first_q <= '0;
            step_q  <= '0;
        end else if (desel) begin
            op_q    <= OP_IDLE;
        end else if (start) begin
            op_q    <= any_lane ? OP_WRITE : OP_READ;
            hi_q    <= addr[ADDR_W-1:BEAT_W];
            first_q <= addr[BEAT_W-1:0];
            step_q  <= '0;
        end else if (adv && (op_q != OP_IDLE)) begin
            step_q  <= step_q + 1'b1;
        end
    end

    // The upper bits stay fixed; the low bits follow the selected beat order
    assign acc_addr_o = {hi_q, beat_lo(first_q, step_q, lin_q)};
    assign op_o       = op_q;

endmodule

// File: rtl/sbsram_array.sv
`timescale 1ns/1ps
// Module: sbsram_array
// The storage array, built as one memory per byte lane. Writes land on the
// rising edge from the registered control stage. Reads are combinational, so
// a read in the cycle after a write sees the new word.
// Assumes a single shared address for the read port and the write port.
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter  int ADDR_W = 10,
    parameter  int LANES  = 4,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wbe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Update this lane only when the burst writes and its enable is set
        always_ff @(posedge clk) begin
            if (wr_en && wbe[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Unregistered read of this lane
        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/sbsram_outstage.sv
`timescale 1ns/1ps
// Module: sbsram_outstage
// The read output stage. It passes the array word through directly, or
// through one rising-edge register, as the registered mode bit selects. The
// data is forced to zero whenever no read beat is valid.
// Assumes rd_live_i is high only during a read beat.
module sbsram_outstage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_i,
    input  logic              rd_live_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic [DATA_W-1:0] flow_word;
    logic [DATA_W-1:0] pipe_q;
    logic              pval_q;

    // The direct path shows zero outside a read beat
    assign flow_word = rd_live_i ? rd_word_i : '0;

    // Output register: holds the beat of the previous cycle for the pipelined path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
            pval_q <= 1'b0;
        end else begin
            pipe_q <= flow_word;
            pval_q <= rd_live_i;
        end
    end

    // Choose the read path
    assign rdata_o  = flow_i ? flow_word : pipe_q;
    assign rvalid_o = flow_i ? rd_live_i : pval_q;

endmodule

// File: rtl/sbsram_top.sv
`timescale 1ns/1ps
// Module: sbsram_top
// A single-port synchronous burst SRAM. Inputs pass through the registered
// sequencer, then the per-lane array, then the selectable output stage.
// Assumes: flow_thru and lin_order are static while a burst is open.
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter  int ADDR_W = 10,
    parameter  int LANES  = 4,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_thru,
    input  logic              lin_order,
    input  logic              start,
    input  logic              adv,
    input  logic              desel,
    input  logic              we_all,
    input  logic [LANES-1:0]  byte_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    burst_op_e         op;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  wbe_q;
    logic              flow_q;
    logic [DATA_W-1:0] rd_word;
    logic              rd_live;
    logic              wr_en;

    assign rd_live = (op == OP_READ);
    assign wr_en   = (op == OP_WRITE);

    sbsram_seq #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flow_thru  (flow_thru),
        .lin_order  (lin_order),
        .start      (start),
        .adv        (adv),
        .desel      (desel),
        .we_all     (we_all),
        .byte_we    (byte_we),
        .addr       (addr),
        .wdata      (wdata),
        .op_o       (op),
        .acc_addr_o (acc_addr),
        .wdata_o    (wdata_q),
        .wbe_o      (wbe_q),
        .flow_o     (flow_q)
    );

    sbsram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_array (
        .clk   (clk),
        .wr_en (wr_en),
        .wbe   (wbe_q),
        .addr  (acc_addr),
        .wdata (wdata_q),
        .rdata (rd_word)
    );

    sbsram_outstage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_i    (flow_q),
        .rd_live_i (rd_live),
        .rd_word_i (rd_word),
        .rdata_o   (rdata),
        .rvalid_o  (rvalid)
    );

endmodule

// File: rtl/sbsram_top_chk.sv
`timescale 1ns/1ps
// Module: sbsram_top_chk
// Port-level timing properties of the burst SRAM, bound to every instance
// of sbsram_top. Assumes the mode inputs are driven from reset onward.
module sbsram_top_chk #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flow_thru,
    input logic              start,
    input logic              adv,
    input logic              desel,
    input logic              we_all,
    input logic [LANES-1:0]  byte_we,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid
);

    logic rd_start;
    assign rd_start = start && !desel && !we_all && (byte_we == '0);

    // R2: on the direct path the first beat is valid right after the start edge
    a_r2_flow_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && flow_thru) |=> rvalid);

    // R3: on the registered path the first beat is valid one edge later
    a_r3_pipe_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_start && !flow_thru) && !flow_thru) |=> rvalid);

    // R6: a held beat keeps the same data on the direct path
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && flow_thru && $past(flow_thru) && !start && !desel && !adv)
        |=> $stable(rdata));

    // R10: on the direct path a deselect releases the output at once
    a_r10_flow_release: assert property (@(posedge clk) disable iff (!rst_n)
        (desel && flow_thru) |=> !rvalid);

    // R10: on the registered path the output releases one cycle later
    a_r10_pipe_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(desel && !flow_thru) && !flow_thru) |=> !rvalid);

    // R11: reset leaves the output quiet
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!rvalid && (rdata == '0)));

    // R12: no data shows without a valid beat
    a_r12_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

endmodule

bind sbsram_top sbsram_top_chk #(
    .LANES  (LANES),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flow_thru (flow_thru),
    .start     (start),
    .adv       (adv),
    .desel     (desel),
    .we_all    (we_all),
    .byte_we   (byte_we),
    .rdata     (rdata),
    .rvalid    (rvalid)
);

// File: tb/sbsram_top_test.sv
`timescale 1ns/1ps
// Bench for sbsram_top: table-driven burst reads, then directed cases.
module sbsram_top_test;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] BASE   = 10'h1A4;
    localparam logic [AW-1:0] ADDR_X = 10'h2C7;

    // Vector fields: [11] flow_thru, [10] lin_order, [9:8] start low bits,
    // [7:0] expected low bits of beats 0..3, beat 0 in the top two bits
    localparam logic [11:0] VEC [8] = '{
        {1'b1, 1'b1, 2'd1, 8'h6C},
        {1'b0, 1'b1, 2'd3, 8'hC6},
        {1'b1, 1'b0, 2'd1, 8'h4E},
        {1'b0, 1'b0, 2'd3, 8'hE4},
        {1'b0, 1'b0, 2'd2, 8'hB1},
        {1'b1, 1'b1, 2'd2, 8'hB1},
        {1'b0, 1'b1, 2'd0, 8'h1B},
        {1'b1, 1'b0, 2'd0, 8'h1B}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flow_thru = 1'b0;
    logic          lin_order = 1'b0;
    logic          start = 1'b0;
    logic          adv = 1'b0;
    logic          desel = 1'b1;
    logic          we_all = 1'b0;
    logic [3:0]    byte_we = '0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    sbsram_top #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .lin_order(lin_order),
        .start(start), .adv(adv), .desel(desel), .we_all(we_all),
        .byte_we(byte_we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [31:0] pat(input logic [AW-1:0] a);
        return 32'hC300_0000 ^ {12'h0, a, 10'h0} ^ {22'h0, a};
    endfunction

    function automatic logic [32:0] seen();
        return {rvalid, rdata};
    endfunction

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        start = 1'b0; adv = 1'b0; desel = 1'b1; we_all = 1'b0; byte_we = '0;
    endtask

    task automatic wr_word(input logic [AW-1:0] a, input logic [31:0] d,
                           input logic [3:0] be, input logic all);
        @(negedge clk);
        start = 1'b1; desel = 1'b0; adv = 1'b0; addr = a; wdata = d; byte_we = be; we_all = all;
        @(negedge clk);
        drive_idle();
    endtask

    // Single read on the direct path: sampled right after the start edge
    task automatic rd_word(input logic [AW-1:0] a, output logic [32:0] got);
        @(negedge clk);
        start = 1'b1; desel = 1'b0; adv = 1'b0; addr = a; byte_we = '0; we_all = 1'b0;
        @(negedge clk);
        got = seen();
        drive_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [32:0] got;
        drive_idle();
        repeat (3) @(negedge clk);
        check("R11 quiet while in reset", seen(), 33'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 quiet after reset", seen(), 33'h0);

        // Fill four words with a linear write burst
        flow_thru = 1'b1; lin_order = 1'b1;
        @(negedge clk);
        start = 1'b1; desel = 1'b0; we_all = 1'b1; addr = BASE; wdata = pat(BASE);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            start = 1'b0; adv = 1'b1; wdata = pat(BASE + AW'(k));
        end
        @(negedge clk);
        drive_idle();

        // Table walk: burst order and latency on both paths
        for (int v = 0; v < 8; v++) begin
            logic [11:0] e;
            int lat;
            e = VEC[v];
            @(negedge clk);
            flow_thru = e[11]; lin_order = e[10]; drive_idle();
            @(negedge clk);
            @(negedge clk);
            start = 1'b1; desel = 1'b0; addr = {BASE[AW-1:2], e[9:8]};
            lat = e[11] ? 0 : 1;
            for (int c = 1; c <= 6; c++) begin
                int idx;
                logic [1:0] lo;
                logic [32:0] exp;
                string tag;
                @(negedge clk);
                idx = c - 1 - lat;
                if (idx >= 0 && idx <= 3) begin
                    lo  = 2'((e[7:0] >> (6 - 2*idx)) & 8'h3);
                    exp = {1'b1, pat({BASE[AW-1:2], lo})};
                    if (c == 5) tag = "R10 registered path holds last beat";
                    else if (e[10]) tag = e[11] ? "R4 R2 linear direct" : "R4 R3 linear registered";
                    else tag = e[11] ? "R5 R2 interleaved direct" : "R5 R3 interleaved registered";
                end else begin
                    exp = 33'h0;
                    tag = (idx < 0) ? "R3 first cycle empty" : "R10 R12 released after deselect";
                end
                check(tag, seen(), exp);
                if (c <= 3) begin
                    start = 1'b0; adv = 1'b1;
                end else begin
                    drive_idle();
                end
            end
        end

        // R1: extreme and top-half addresses hold distinct words
        @(negedge clk);
        flow_thru = 1'b1; lin_order = 1'b1; drive_idle();
        wr_word('0, 32'h0BAD_0001, 4'h0, 1'b1);
        wr_word(AW'(DEPTH - 1), 32'h0BAD_0002, 4'h0, 1'b1);
        wr_word({1'b1, {(AW-1){1'b0}}}, 32'h0BAD_0003, 4'h0, 1'b1);
        rd_word('0, got);
        check("R1 lowest word", got, {1'b1, 32'h0BAD_0001});
        rd_word(AW'(DEPTH - 1), got);
        check("R1 highest word", got, {1'b1, 32'h0BAD_0002});
        rd_word({1'b1, {(AW-1){1'b0}}}, got);
        check("R1 top-half word", got, {1'b1, 32'h0BAD_0003});

        // R7 and R9: lanes 0 and 2 written, read in the very next cycle
        wr_word(ADDR_X, 32'h1122_3344, 4'h0, 1'b1);
        @(negedge clk);
        start = 1'b1; desel = 1'b0; addr = ADDR_X; wdata = 32'hAABB_CCDD; byte_we = 4'b0101;
        @(negedge clk);
        byte_we = 4'b0000; wdata = '0;
        @(negedge clk);
        check("R7 R9 lanes 0,2 then back-to-back read", seen(), {1'b1, 32'h11BB_33DD});
        drive_idle();
        wr_word(ADDR_X, 32'h7700_0000, 4'b1000, 1'b0);
        rd_word(ADDR_X, got);
        check("R7 lane 3 only", got, {1'b1, 32'h77BB_33DD});

        // R8: global write overrides a single lane enable
        wr_word(ADDR_X, 32'hDEAD_BEEF, 4'b0001, 1'b1);
        rd_word(ADDR_X, got);
        check("R8 global write", got, {1'b1, 32'hDEAD_BEEF});

        // R6: holding advance low repeats the beat
        @(negedge clk);
        start = 1'b1; desel = 1'b0; adv = 1'b0; addr = {BASE[AW-1:2], 2'd2};
        @(negedge clk);
        check("R6 first beat", seen(), {1'b1, pat({BASE[AW-1:2], 2'd2})});
        start = 1'b0;
        @(negedge clk);
        check("R6 held once", seen(), {1'b1, pat({BASE[AW-1:2], 2'd2})});
        @(negedge clk);
        check("R6 held twice", seen(), {1'b1, pat({BASE[AW-1:2], 2'd2})});
        adv = 1'b1;
        @(negedge clk);
        check("R6 steps after hold", seen(), {1'b1, pat({BASE[AW-1:2], 2'd3})});
        drive_idle();
        @(negedge clk);
        check("R10 direct path released", seen(), 33'h0);

        // R10: deselect wins over a start in the same cycle
        start = 1'b1; desel = 1'b1; addr = BASE;
        @(negedge clk);
        check("R10 deselect beats start", seen(), 33'h0);
        drive_idle();

        // R11: reset during a registered-path burst
        flow_thru = 1'b0;
        @(negedge clk);
        start = 1'b1; desel = 1'b0; addr = BASE;
        @(negedge clk);
        start = 1'b0; adv = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; drive_idle();
        check("R11 reset mid-burst", seen(), 33'h0);
        @(negedge clk);
        check("R11 burst gone after reset", seen(), 33'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule